// File: doc/BRIEF.md
# Multi-Length Pseudo-Random Pattern Generator and Checker

This block holds one 31-bit shift register that can run any of five maximal-length linear feedback loops. A static 3-bit length code picks the loop. With the loop closed, the block emits a pseudo-random pattern of length 2^7-1, 2^10-1, 2^15-1, 2^23-1 or 2^31-1, one bit per clock. With the loop open, the register loads the serial input instead. It then predicts each incoming bit from the bits it has already received, and it flags every bit that disagrees with the prediction.

In a typical test setup, the receiving instance first trains with its loop open. It locks onto the incoming stream once as many correct bits have arrived as the loop is long, and the mismatch output then stays low. The loop is then closed so that the register runs on its own. From that point each corrupted input bit produces exactly one mismatch pulse, rather than one pulse for every tap the bad bit would pass through. A small two-state controller holds the loop mode and takes the mode input on each clock.

Top module: `prbs_core`

## Requirements
- R1: While reset is high at a clock edge, every register bit is set to 1, the mismatch output is cleared to 0 and the controller enters the closed-loop state. So during reset pat_out reads 1 and err reads 0.
- R2: The length code len_sel is decoded as follows:
  - 000 selects x^7+x^6+1
  - 001 selects x^10+x^7+1
  - 010 selects x^15+x^14+1
  - 011 selects x^23+x^18+1
  - 100 selects x^31+x^28+1

  In closed-loop operation from reset, one period of 2^n-1 bits contains exactly 2^(n-1) ones.
- R3: The codes 101, 110 and 111 produce the same pattern as code 100.
- R4: In closed-loop operation, each new pat_out bit is the XOR of the bits emitted n and k clocks earlier, where x^n+x^k+1 is the selected polynomial. Every bit from before reset release counts as 1, so the first bit after release is 0.
- R5: The controller samples enc at each clock edge. enc=1 leads to the closed state (CLOSE transition) and enc=0 leads to the open state (OPEN transition). The new state governs the register from the following edge onward.
- R6: In the open state, pat_out equals the din value sampled at the previous clock edge.
- R7: err is registered. At each edge it takes din XOR the predicted bit, which is the XOR of the selected taps before the shift. This holds in both states.
- R8: In the open state, once n consecutive bits of a valid sequence have been received, err stays 0 for as long as din keeps following that sequence.
- R9: A single inverted input bit produces three err pulses in the open state, one each at 0, k and n clocks after the bad bit arrives. In the closed state it produces exactly one pulse and leaves pat_out unchanged.
- R10: In the closed state, a nonzero register never becomes all-zero. The longest run of zeros in the output is n-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data received from the pattern under test |
| len_sel | input | 3 | Static sequence length code |
| enc | input | 1 | Loop mode: 1 closed (generate or free-run), 0 open (track din) |
| pat_out | output | 1 | Newest register bit; the generated or tracked pattern |
| err | output | 1 | Registered mismatch between din and the predicted bit |

## Verification
A corrupted register bit or a wrong tap shows up on pat_out as a departure from the reference recurrence. In closed-loop operation it appears no later than n clocks after the bad bit enters, because that is when the oldest tap reads it. The length-specific ones count over a full period exposes a wrong tap pairing even when the first bits happen to agree. A stuck or late mode controller shows up on the edge right after enc changes, as pat_out following din or ignoring it. A broken open or closed path shows up as the wrong number of err pulses after a single injected bit error.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int NUM_LOOPS = 5;
    localparam int MAX_ORDER = 31;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_CLOSED = 1'b1
    } loop_state_e;

    // Order n of loop idx (polynomial x^n + x^k + 1)
    function automatic int loop_order(input int idx);
        case (idx)
            0:       return 7;
            1:       return 10;
            2:       return 15;
            3:       return 23;
            default: return 31;
        endcase
    endfunction

    // Inner tap k of loop idx
    function automatic int loop_inner(input int idx);
        case (idx)
            0:       return 6;
            1:       return 7;
            2:       return 14;
            3:       return 18;
            default: return 28;
        endcase
    endfunction

endpackage

// File: rtl/prbs_tap_select.sv
module prbs_tap_select
    import prbs_pkg::*;
#(
    parameter int REG_W = MAX_ORDER
) (
    input  logic [REG_W-1:0] shreg,
    input  logic [2:0]       len_sel,
    output logic             pred_bit
);

    // Bit of age a (1 = newest) sits at shreg[a-1].
    logic [NUM_LOOPS-1:0] loop_fb;

    generate
        for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
            localparam int ORD = loop_order(g);
            localparam int INR = loop_inner(g);
            assign loop_fb[g] = shreg[ORD-1] ^ shreg[INR-1];
        end
    endgenerate

    always_comb begin
        case (len_sel)
            3'b000:  pred_bit = loop_fb[0];
            3'b001:  pred_bit = loop_fb[1];
            3'b010:  pred_bit = loop_fb[2];
            3'b011:  pred_bit = loop_fb[3];
            default: pred_bit = loop_fb[4];
        endcase
    end

endmodule

// File: rtl/prbs_loop_ctrl.sv
module prbs_loop_ctrl
    import prbs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enc,
    output logic loop_closed
);

    loop_state_e state_q;
    loop_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_OPEN:   state_d = enc ? ST_CLOSED : ST_OPEN;   // CLOSE
            ST_CLOSED: state_d = enc ? ST_CLOSED : ST_OPEN;   // OPEN
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_CLOSED;
        else     state_q <= state_d;
    end

    always_comb begin
        loop_closed = (state_q == ST_CLOSED);
    end

endmodule

// File: rtl/prbs_shift_reg.sv
module prbs_shift_reg #(
    parameter int REG_W = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             loop_closed,
    input  logic             pred_bit,
    input  logic             din,
    output logic [REG_W-1:0] shreg
);

    logic next_bit;

    always_comb begin
        next_bit = loop_closed ? pred_bit : din;
    end

    always_ff @(posedge clk) begin
        if (rst) shreg <= '1;
        else     shreg <= {shreg[REG_W-2:0], next_bit};
    end

endmodule

// File: rtl/prbs_core.sv
module prbs_core
    import prbs_pkg::*;
#(
    parameter int REG_W = MAX_ORDER
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic [2:0] len_sel,
    input  logic       enc,
    output logic       pat_out,
    output logic       err
);

    logic [REG_W-1:0] shreg;
    logic             pred_bit;
    logic             loop_closed;
    logic             err_q;

    prbs_loop_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .enc         (enc),
        .loop_closed (loop_closed)
    );

    prbs_tap_select #(.REG_W(REG_W)) u_taps (
        .shreg    (shreg),
        .len_sel  (len_sel),
        .pred_bit (pred_bit)
    );

    prbs_shift_reg #(.REG_W(REG_W)) u_sreg (
        .clk         (clk),
        .rst         (rst),
        .loop_closed (loop_closed),
        .pred_bit    (pred_bit),
        .din         (din),
        .shreg       (shreg)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= din ^ pred_bit;
    end

    assign pat_out = shreg[0];
    assign err     = err_q;

endmodule

// File: rtl/prbs_core_chk.sv
module prbs_core_chk #(
    parameter int REG_W = 31
) (
    input logic             clk,
    input logic             rst,
    input logic             din,
    input logic             enc,
    input logic             pat_out,
    input logic             err,
    input logic             loop_closed,
    input logic             pred_bit,
    input logic [REG_W-1:0] shreg
);

    AST_OPEN_ECHO: assert property (@(posedge clk) disable iff (rst)
        !loop_closed |=> (pat_out == $past(din)));                    // R6

    AST_CLOSED_PREDICT: assert property (@(posedge clk) disable iff (rst)
        loop_closed |=> (pat_out == $past(pred_bit)));                // R4

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
        (loop_closed && shreg != '0) |=> (shreg != '0));              // R10

    AST_ERR_CLOSED: assert property (@(posedge clk) disable iff (rst)
        loop_closed |=> (err == ($past(din) ^ pat_out)));             // R7

    AST_MODE_CLOSE: assert property (@(posedge clk) disable iff (rst)
        enc |=> loop_closed);                                         // R5

    AST_MODE_OPEN: assert property (@(posedge clk) disable iff (rst)
        !enc |=> !loop_closed);                                       // R5

endmodule

bind prbs_core prbs_core_chk #(.REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .din         (din),
    .enc         (enc),
    .pat_out     (pat_out),
    .err         (err),
    .loop_closed (loop_closed),
    .pred_bit    (pred_bit),
    .shreg       (shreg)
);

// File: tb/sim_prbs_core.sv
`timescale 1ns/1ps
module sim_prbs_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [2:0] len_sel = 3'b000;
    logic       enc = 1'b1;
    logic       pat_out;
    logic       err;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #4 clk = ~clk;

    prbs_core u0 (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .len_sel (len_sel),
        .enc     (enc),
        .pat_out (pat_out),
        .err     (err)
    );

    localparam int NV = 8;
    localparam logic [2:0] VSEL [NV] = '{3'b000, 3'b001, 3'b010, 3'b011,
                                         3'b100, 3'b101, 3'b110, 3'b111};
    localparam int VORD [NV] = '{7, 10, 15, 23, 31, 31, 31, 31};
    localparam int VINR [NV] = '{6, 7, 14, 18, 28, 28, 28, 28};
    localparam int VPER [NV] = '{127, 1023, 32767, 0, 0, 0, 0, 0};

    logic [30:0] mh;

    function automatic logic adv(inout logic [30:0] st, input int n, input int k);
        logic nb;
        nb = st[n-1] ^ st[k-1];
        st = {st[29:0], nb};
        return nb;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        enc = 1'b1;
        din = 1'b0;
        repeat (2) tick();
        check(pat_out === 1'b1, "R1", "pat_out in reset", int'(pat_out), 1);
        check(err === 1'b0, "R1", "err in reset", int'(err), 0);
        rst = 1'b0;
        mh  = '1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Lock, single-error and close tests on one length code
    task automatic detect(input logic [2:0] sel, input int n, input int k, input int skip);
        logic [30:0] gh;
        logic b;
        int bad, echo_bad, pulses;
        len_sel = sel;
        do_reset();
        gh = '1;
        for (int i = 0; i < skip; i++) b = adv(gh, n, k);
        enc = 1'b0; din = 1'b0;
        repeat (2) tick();
        bad = 0; echo_bad = 0;
        for (int c = 0; c < n + 40; c++) begin
            din = adv(gh, n, k);
            tick();
            if (pat_out !== din) echo_bad++;
            if (c >= n && err !== 1'b0) bad++;
        end
        check(bad == 0, "R8", "err after lock, open", bad, 0);
        check(echo_bad == 0, "R6", "open echo mismatches", echo_bad, 0);
        // single error, open loop
        pulses = 0;
        din = ~adv(gh, n, k);
        tick();
        if (err === 1'b1) pulses++;
        for (int c = 0; c < n + 8; c++) begin
            din = adv(gh, n, k);
            tick();
            if (err === 1'b1) pulses++;
        end
        check(pulses == 3, "R9", "open-loop pulses per error", pulses, 3);
        // close the loop while the stream stays correct
        din = adv(gh, n, k); enc = 1'b1;
        tick();
        bad = 0; echo_bad = 0;
        for (int c = 0; c < 30; c++) begin
            din = adv(gh, n, k);
            tick();
            if (err !== 1'b0) bad++;
            if (pat_out !== din) echo_bad++;
        end
        check(bad == 0, "R8", "err after closing", bad, 0);
        check(echo_bad == 0, "R4", "free-run follows stream", echo_bad, 0);
        // single error, closed loop
        pulses = 0; echo_bad = 0;
        b = adv(gh, n, k);
        din = ~b;
        tick();
        if (err === 1'b1) pulses++;
        if (pat_out !== b) echo_bad++;
        for (int c = 0; c < n + 8; c++) begin
            b = adv(gh, n, k);
            din = b;
            tick();
            if (err === 1'b1) pulses++;
            if (pat_out !== b) echo_bad++;
        end
        check(pulses == 1, "R9", "closed-loop pulses per error", pulses, 1);
        check(echo_bad == 0, "R9", "closed pattern disturbed", echo_bad, 0);
    endtask

    initial begin
        #(8ns * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int bad, ones, zrun, maxz, run;
        logic e;
        // Vector table walk: generator mode for every length code
        for (int v = 0; v < NV; v++) begin
            len_sel = VSEL[v];
            do_reset();
            run = (VPER[v] > 0) ? VPER[v] + 31 : 3000;
            bad = 0; ones = 0; zrun = 0; maxz = 0;
            for (int c = 0; c < run; c++) begin
                tick();
                e = adv(mh, VORD[v], VINR[v]);
                if (pat_out !== e) bad++;
                if (c < VPER[v] && pat_out === 1'b1) ones++;
                if (pat_out === 1'b0) begin
                    zrun++;
                    if (zrun > maxz) maxz = zrun;
                end else zrun = 0;
            end
            if (v < 5) check(bad == 0, "R2", "sequence mismatches (R4)", bad, 0);
            else       check(bad == 0, "R3", "fold-to-31 mismatches", bad, 0);
            if (VPER[v] > 0) begin
                check(ones == (VPER[v] + 1) / 2, "R2", "ones per period", ones, (VPER[v] + 1) / 2);
                check(maxz == VORD[v] - 1, "R10", "longest zero run", maxz, VORD[v] - 1);
            end
        end

        // R5/R6/R7: mode latency at the edge where enc drops
        len_sel = 3'b000;
        do_reset();
        e = adv(mh, 7, 6);
        enc = 1'b0; din = ~e;
        tick();
        check(pat_out === e, "R5", "closed still governs first edge", int'(pat_out), int'(e));
        check(err === 1'b1, "R7", "err on mismatched din", int'(err), 1);
        din = 1'b1;
        tick();
        check(pat_out === 1'b1, "R5", "open governs next edge", int'(pat_out), 1);
        din = 1'b0;
        tick();
        check(pat_out === 1'b0, "R6", "open echoes din", int'(pat_out), 0);

        detect(3'b000, 7, 6, 57);
        detect(3'b100, 31, 28, 200);
        detect(3'b010, 15, 14, 90);

        finish_run();
    end

endmodule